// File: doc/BRIEF.md
# DMA Bus Bandwidth Throttle

This block sits between the minor-loop read/write sequencer of a DMA engine and its bus master port. It decides whether the engine may issue its next access. A two-bit bandwidth setting selects one of four policies: no throttling, raised arbitration priority, a short stall after each read/write pair, or a long stall after each pair. The stall output holds off the sequencer. The priority output goes to the crossbar arbiter.

Stalls are meant to limit bus load, not to add start-up latency. For that reason no stall is inserted while a newly started channel has completed fewer than two bus cycles. No stall is inserted after the pair that carries the final write of a minor loop either. Priority elevation is also held off until those first two bus cycles have completed. A stall that has begun always runs to its full loaded length, even if the setting changes while it is in progress.

Top module: `dma_bw_throttle`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `stall` and `prio_elev` are low, and the bus cycle count is zero.
- R2: With `bw_mode` = 2'b00, `stall` never rises and `prio_elev` stays low.
- R3: With `bw_mode` = 2'b01, `stall` never rises. `prio_elev` is high while `chan_active` is high and at least two bus cycles have completed since the last `chan_start`.
- R4: With `bw_mode` = 2'b10, a qualifying `pair_done` makes `stall` high for exactly 4 consecutive cycles, starting in the cycle after the pulse.
- R5: With `bw_mode` = 2'b11, a qualifying `pair_done` makes `stall` high for exactly 8 consecutive cycles, starting in the cycle after the pulse.
- R6: A `pair_done` does not stall while fewer than two `bus_cyc_done` pulses have been registered since the last `chan_start`. A `bus_cyc_done` in the same cycle as the `pair_done` is not yet counted.
- R7: A `pair_done` with `last_write` high never starts a stall.
- R8: `prio_elev` is low whenever `chan_active` is low, and it stays low until the second bus cycle after `chan_start` has been registered, in every mode.
- R9: `chan_start` clears the bus cycle count, which saturates at 2. A `pair_done` in the same cycle as `chan_start` does not stall.
- R10: Once a stall has begun, it runs for its originally loaded length. Changes of `bw_mode` and further `pair_done` pulses during the stall do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_mode | input | 2 | Bandwidth setting: 00 none, 01 elevate, 10 short stall, 11 long stall |
| chan_active | input | 1 | A channel is currently executing |
| chan_start | input | 1 | Pulse: a new channel begins service |
| bus_cyc_done | input | 1 | Pulse: one bus access completed |
| pair_done | input | 1 | Pulse: one read/write pair completed |
| last_write | input | 1 | Qualifies `pair_done`: the pair ends the minor loop |
| stall | output | 1 | Holds off the sequencer's next access |
| prio_elev | output | 1 | Elevated-priority request to the crossbar arbiter |

## Verification
Start-up suppression and stall arming can fall in the same cycle. This happens when the `pair_done` of the first pair arrives together with the second `bus_cyc_done`. The bench drives exactly that coincidence in the long-stall mode. It expects no stall there, and then a full 8-cycle stall on the next pair, because the count has by then reached two. A second collision, `chan_start` together with `pair_done` on a saturated count, is judged the same way: the expected stall length is zero.

// File: rtl/dma_bw_pkg.sv
package dma_bw_pkg;
   typedef enum logic [1:0] {
      BW_NONE    = 2'b00,
      BW_ELEVATE = 2'b01,
      BW_SHORT   = 2'b10,
      BW_LONG    = 2'b11
   } bw_mode_e;
endpackage

// File: rtl/dma_bw_startup_gate.sv
module dma_bw_startup_gate #(
   parameter int SUPPRESS_CYCLES = 2,
   parameter int CW              = $clog2(SUPPRESS_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_start,
   input  logic bus_cyc_done,
   output logic past_startup
);
   localparam logic [CW-1:0] SAT = CW'(SUPPRESS_CYCLES);

   logic [CW-1:0] cyc_q;

   initial assert_cfg_suppress_R6 : assert (SUPPRESS_CYCLES >= 1)
      else $error("SUPPRESS_CYCLES must be at least 1");

   always_ff @(posedge clk) begin
      if (!rst_n)
         cyc_q <= '0;
      else if (chan_start)
         cyc_q <= '0;
      else if (bus_cyc_done && cyc_q != SAT)
         cyc_q <= cyc_q + 1'b1;
   end

   assign past_startup = (cyc_q == SAT);

   assert_saturate_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q <= SAT);

   assert_restart_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      chan_start |=> (cyc_q == '0));

   assert_hold_sat_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (past_startup && !chan_start) |=> past_startup);
endmodule

// File: rtl/dma_bw_stall_timer.sv
module dma_bw_stall_timer #(
   parameter int MAX_LEN = 8,
   parameter int CW      = $clog2(MAX_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_len,
   output logic          stall
);
   logic [CW-1:0] left_q;

   initial assert_cfg_len_R4 : assert (MAX_LEN >= 1)
      else $error("MAX_LEN must be at least 1");

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
      else if (load)
         left_q <= load_len;
   end

   assign stall = (left_q != '0);

   assert_count_down_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

   assert_load_len_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (load && left_q == '0) |=> (left_q == $past(load_len)));

   assert_idle_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && left_q == '0) |=> (left_q == '0));
endmodule

// File: rtl/dma_bw_throttle.sv
module dma_bw_throttle
   import dma_bw_pkg::*;
#(
   parameter int SHORT_STALL     = 4,
   parameter int LONG_STALL      = 8,
   parameter int SUPPRESS_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bw_mode,
   input  logic       chan_active,
   input  logic       chan_start,
   input  logic       bus_cyc_done,
   input  logic       pair_done,
   input  logic       last_write,
   output logic       stall,
   output logic       prio_elev
);
   localparam int MAX_LEN = (LONG_STALL > SHORT_STALL) ? LONG_STALL : SHORT_STALL;
   localparam int LW      = $clog2(MAX_LEN + 1);

   initial assert_cfg_short_R4 : assert (SHORT_STALL >= 1)
      else $error("SHORT_STALL must be at least 1");
   initial assert_cfg_long_R5 : assert (LONG_STALL >= SHORT_STALL)
      else $error("LONG_STALL must not be below SHORT_STALL");

   bw_mode_e      mode;
   logic          past_startup;
   logic          stall_arm;
   logic          load;
   logic [LW-1:0] len_sel;

   assign mode = bw_mode_e'(bw_mode);

   generate
      if (SHORT_STALL == LONG_STALL) begin : g_one_len
         assign len_sel = LW'(SHORT_STALL);
      end else begin : g_two_len
         assign len_sel = (mode == BW_LONG) ? LW'(LONG_STALL) : LW'(SHORT_STALL);
      end
   endgenerate

   dma_bw_startup_gate #(
      .SUPPRESS_CYCLES(SUPPRESS_CYCLES)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_start  (chan_start),
      .bus_cyc_done(bus_cyc_done),
      .past_startup(past_startup)
   );

   assign stall_arm = (mode == BW_SHORT) || (mode == BW_LONG);
   assign load      = pair_done && !last_write && !chan_start && past_startup && stall_arm;

   dma_bw_stall_timer #(
      .MAX_LEN(MAX_LEN),
      .CW     (LW)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_len(len_sel),
      .stall   (stall)
   );

   assign prio_elev = chan_active && past_startup && (mode == BW_ELEVATE);

   assert_none_mode_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BW_NONE && !stall) |=> !stall);

   assert_elev_no_stall_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BW_ELEVATE && !stall) |=> !stall);

   assert_startup_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!past_startup && !stall) |=> !stall);

   assert_last_no_stall_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pair_done && last_write && !stall) |=> !stall);

   assert_prio_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      chan_start |=> !prio_elev);

   assert_reset_R1 : assert property (@(posedge clk)
      !rst_n |=> (!stall && !prio_elev));
endmodule

// File: tb/dma_bw_throttle_test.sv
`timescale 1ns/1ps
module dma_bw_throttle_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bw_mode = 2'b00;
   logic       chan_active = 1'b0;
   logic       chan_start = 1'b0;
   logic       bus_cyc_done = 1'b0;
   logic       pair_done = 1'b0;
   logic       last_write = 1'b0;
   logic       stall;
   logic       prio_elev;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dma_bw_throttle uut (
      .clk(clk), .rst_n(rst_n), .bw_mode(bw_mode), .chan_active(chan_active),
      .chan_start(chan_start), .bus_cyc_done(bus_cyc_done), .pair_done(pair_done),
      .last_write(last_write), .stall(stall), .prio_elev(prio_elev)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic restart_chan(input int k);
      chan_start = 1'b1;
      @(negedge clk);
      chan_start = 1'b0;
      for (int j = 0; j < k; j++) begin
         bus_cyc_done = 1'b1;
         @(negedge clk);
      end
      bus_cyc_done = 1'b0;
   endtask

   // counts stall-high samples over 12 cycles, starting at the current negedge
   task automatic measure(output int n);
      n = 0;
      for (int i = 0; i < 12; i++) begin
         if (stall) n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_pair(input bit last);
      pair_done  = 1'b1;
      last_write = last;
      @(negedge clk);
      pair_done  = 1'b0;
      last_write = 1'b0;
   endtask

   initial begin
      int n;
      int exp_n;
      bw_mode     = 2'b01;
      chan_active = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset stall", int'(stall), 0);
      check("R1 reset prio", int'(prio_elev), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-reset prio (count zero)", int'(prio_elev), 0);

      // sweep: mode x last_write x bus cycles before the pair
      for (int m = 0; m < 4; m++) begin
         for (int l = 0; l < 2; l++) begin
            for (int k = 0; k < 4; k++) begin
               bw_mode = 2'(m);
               restart_chan(k);
               check($sformatf("R3/R8 prio m=%0d k=%0d", m, k), int'(prio_elev),
                     (m == 1 && k >= 2) ? 1 : 0);
               pulse_pair(l[0]);
               measure(n);
               exp_n = (m >= 2 && l == 0 && k >= 2) ? ((m == 3) ? 8 : 4) : 0;
               check($sformatf("R2/R4/R5/R6/R7 stall m=%0d last=%0d k=%0d", m, l, k),
                     n, exp_n);
            end
         end
      end

      // R8: inactive channel never elevated
      bw_mode = 2'b01;
      restart_chan(3);
      chan_active = 1'b0;
      #1;
      check("R8 prio with channel idle", int'(prio_elev), 0);
      chan_active = 1'b1;
      #1;
      check("R9 count saturated, prio back", int'(prio_elev), 1);

      // coincidence: second bus cycle and first pair in the same cycle (R6)
      bw_mode = 2'b11;
      restart_chan(1);
      bus_cyc_done = 1'b1;
      pair_done    = 1'b1;
      @(negedge clk);
      bus_cyc_done = 1'b0;
      pair_done    = 1'b0;
      measure(n);
      check("R6 pair coincident with second bus cycle", n, 0);
      pulse_pair(1'b0);
      measure(n);
      check("R6 next pair after count reached two", n, 8);

      // R9: chan_start together with pair_done on a saturated count
      restart_chan(2);
      chan_start = 1'b1;
      pair_done  = 1'b1;
      @(negedge clk);
      chan_start = 1'b0;
      pair_done  = 1'b0;
      measure(n);
      check("R9 pair with chan_start", n, 0);

      // R10: mode change during a long stall keeps length 8
      bw_mode = 2'b11;
      restart_chan(2);
      pulse_pair(1'b0);
      n = 0;
      for (int i = 0; i < 12; i++) begin
         if (stall) n++;
         if (i == 1) bw_mode = 2'b10;
         if (i == 3) bw_mode = 2'b00;
         @(negedge clk);
      end
      check("R10 mode change mid stall", n, 8);

      // R10: extra pair_done during a short stall is ignored
      bw_mode = 2'b10;
      restart_chan(2);
      pulse_pair(1'b0);
      n = 0;
      for (int i = 0; i < 12; i++) begin
         if (stall) n++;
         pair_done = (i == 1);
         @(negedge clk);
      end
      pair_done = 1'b0;
      check("R10 pair during stall", n, 4);

      // R4: stall begins the cycle after the pulse
      restart_chan(2);
      pair_done = 1'b1;
      #1;
      check("R4 no stall in pulse cycle", int'(stall), 0);
      @(negedge clk);
      pair_done = 1'b0;
      check("R4 stall in following cycle", int'(stall), 1);
      repeat (6) @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule